// File: doc/BRIEF.md
# Conversion Start Sequencer

This block times each analog-to-digital conversion. A conversion can start in two ways. The first is a program start request. This path waits a fixed settling interval so the switched-gain amplifier can settle, and then issues the converter start pulse. The second is an external trigger. This path issues the start pulse as soon as a qualified trigger is seen, with no settling wait. Every interval is counted in cycles of one fixed system clock. Each interval is derived from a clock-frequency parameter and a duration in nanoseconds, rounded up to whole cycles.

The external trigger is asynchronous. It passes through a two-flop synchroniser, and a falling edge is detected after that point. The line must then stay low for a minimum number of cycles before the trigger counts. External triggers are honoured only while the external-enable input is high.

A conversion stays "open" from its start request until its result has been read. A trigger that lands while a conversion is open does not start a new conversion. Instead it sets a sticky error flag. The error flag is cleared when the next program start is accepted.

Top module: `conv_seq`

## Requirements
- R1: After reset, conv_start_o and error_o are low.
- R2: A start_req_i sampled high at clock edge k while idle makes conv_start_o high for exactly one cycle, the cycle after edge k+SETTLE_CYC. SETTLE_CYC is 625 at the defaults (125 MHz, 5000 ns).
- R3: start_req_i is ignored while settling or converting. It neither shortens nor lengthens the settle, and it produces no extra start pulse.
- R4: The first clock edge that samples ext_trig_i low begins the trigger path (call it edge p). If the line stays low for MIN_LOW_CYC cycles, the block is idle and no result is unread, conv_start_o is high in the cycle after edge p+MIN_LOW_CYC+1. MIN_LOW_CYC is 7 at the defaults (50 ns rounded up).
- R5: A low pulse on ext_trig_i shorter than MIN_LOW_CYC cycles starts nothing. A line held low yields exactly one trigger per falling edge.
- R6: While ext_en_i is low, ext_trig_i has no effect on conv_start_o or error_o.
- R7: An accepted trigger sets error_o and starts no conversion in any of these cases: it arrives while settling, while converting, or while idle with a result unread. error_o stays high after a result read.
- R8: An accepted program start clears error_o. If an error-setting trigger falls in the same cycle as the start, error_o is set and the program start still proceeds.
- R9: conv_done_i while converting returns the block to idle and marks the result unread until result_rd_i. conv_done_i at any other time is ignored.
- R10: If an accepted trigger and start_req_i fall in the same cycle while idle with nothing unread, the trigger wins. The converter is started at once, and no settled second start follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_req_i | input | 1 | Program start request, one cycle |
| ext_trig_i | input | 1 | Asynchronous external trigger, active on falling edge |
| ext_en_i | input | 1 | Enables the external trigger path |
| result_rd_i | input | 1 | Strobe: the result has been read |
| conv_done_i | input | 1 | Converter finished |
| conv_start_o | output | 1 | One-cycle converter start pulse |
| error_o | output | 1 | Sticky trigger-overlap error |

## Verification
The interesting collisions are a qualified trigger landing in the same cycle as a program start request.

- In one case the block is idle with nothing unread. Here the trigger must win and start the converter immediately.
- In the other case a result is still unread. Here the trigger must set the error while the program start still clears and enters settling, and the set must dominate.

The bench provokes both collisions by counting edges from the trigger's falling edge, so that start_req_i is sampled on the same edge that the trigger qualifies. The outcome is judged against a behavioural model on every clock, and with explicit checks on error_o and on where the start pulse lands.

// File: rtl/cseq_pkg.sv
package cseq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SETTLE, ST_CONV} seq_state_e;

  function automatic int ns_to_cyc(input int mhz, input int ns);
    return (mhz * ns + 999) / 1000;
  endfunction
endpackage

// File: rtl/trig_qual.sv
module trig_qual #(
  parameter int MIN_LOW = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic fire_o
);
  localparam int CW = $clog2(MIN_LOW + 1);
  localparam logic [CW-1:0] LOW_MAX = CW'(MIN_LOW);
  localparam logic [CW-1:0] LOW_HIT = CW'(MIN_LOW - 1);

  logic s1_q, s2_q;
  logic [CW-1:0] low_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= trig_i;
      s2_q <= s1_q;
    end
  end

  // cycles spent low since the last synchronised fall, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          low_q <= '0;
    else if (s2_q)        low_q <= '0;
    else if (low_q != LOW_MAX) low_q <= low_q + 1'b1;
  end

  assign fire_o = !s2_q && (low_q == LOW_HIT);

  a_r5_single_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> !fire_o);

  if (MIN_LOW > 1) begin : g_width
    a_r5_no_fire_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(s2_q) |-> !fire_o);
  end
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int CYC = 625
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int W = (CYC > 1) ? $clog2(CYC) : 1;
  localparam logic [W-1:0] LOAD_VAL = W'(CYC - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (load_i)               cnt_q <= LOAD_VAL;
    else if (run_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = run_i && (cnt_q == '0);
endmodule

// File: rtl/conv_seq.sv
module conv_seq
  import cseq_pkg::*;
#(
  parameter int CLK_MHZ    = 125,
  parameter int SETTLE_NS  = 5000,
  parameter int MIN_LOW_NS = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_req_i,
  input  logic ext_trig_i,
  input  logic ext_en_i,
  input  logic result_rd_i,
  input  logic conv_done_i,
  output logic conv_start_o,
  output logic error_o
);
  localparam int SETTLE_RAW  = ns_to_cyc(CLK_MHZ, SETTLE_NS);
  localparam int SETTLE_CYC  = (SETTLE_RAW < 1) ? 1 : SETTLE_RAW;
  localparam int MIN_LOW_RAW = ns_to_cyc(CLK_MHZ, MIN_LOW_NS);
  localparam int MIN_LOW_CYC = (MIN_LOW_RAW < 1) ? 1 : MIN_LOW_RAW;

  seq_state_e state_q, state_d;
  logic trig_fire, acc_trig, busy, conflict, trig_go, prog_go, settle_done;
  logic start_d, err_q, err_d, pend_q, pend_d, start_q;

  trig_qual #(.MIN_LOW(MIN_LOW_CYC)) u_trig (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (ext_trig_i),
    .fire_o (trig_fire)
  );

  assign acc_trig = trig_fire && ext_en_i;
  assign busy     = (state_q != ST_IDLE);
  assign conflict = acc_trig && (busy || pend_q);
  assign trig_go  = acc_trig && !busy && !pend_q;
  assign prog_go  = start_req_i && !busy && !trig_go;

  settle_timer #(.CYC(SETTLE_CYC)) u_settle (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (prog_go),
    .run_i     (state_q == ST_SETTLE),
    .expired_o (settle_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (trig_go) state_d = ST_CONV;
                 else if (prog_go) state_d = ST_SETTLE;
      ST_SETTLE: if (settle_done) state_d = ST_CONV;
      ST_CONV:   if (conv_done_i) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  assign start_d = trig_go || (state_q == ST_SETTLE && settle_done);
  assign err_d   = conflict || (err_q && !prog_go);   // set dominates clear
  assign pend_d  = (state_q == ST_CONV && conv_done_i) || (pend_q && !result_rd_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      start_q <= 1'b0;
      err_q   <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= start_d;
      err_q   <= err_d;
      pend_q  <= pend_d;
    end
  end

  assign conv_start_o = start_q;
  assign error_o      = err_q;

  a_r2_start_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> !conv_start_o);
  a_r3_settle_not_cut: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SETTLE && !settle_done) |=> (state_q == ST_SETTLE && !conv_start_o));
  a_r6_ext_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !ext_en_i) |=> !conv_start_o);
  a_r7_err_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(error_o) |-> $past(ext_en_i));
  a_r7_conflict_no_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conflict && state_q != ST_SETTLE) |=> !conv_start_o);
  a_r9_done_to_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CONV && conv_done_i) |=> (state_q == ST_IDLE && !conv_start_o));
endmodule

// File: tb/conv_seq_test.sv
module conv_seq_test;
  localparam int S = 625;
  localparam int N = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_req = 1'b0, ext_trig = 1'b1, ext_en = 1'b0;
  logic result_rd = 1'b0, conv_done = 1'b0;
  logic conv_start, err;

  int vectors = 0, fails = 0, cycles = 0;

  always #4 clk = ~clk;

  conv_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .start_req_i(start_req), .ext_trig_i(ext_trig),
    .ext_en_i(ext_en), .result_rd_i(result_rd), .conv_done_i(conv_done),
    .conv_start_o(conv_start), .error_o(err)
  );

  // behavioural reference
  int m_mode, m_left, m_low;
  bit m_s1, m_s2, m_start, m_err, m_pend, fire, acc, p_old, set_err, clr, done_evt;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_left = 0; m_low = 0; m_s1 = 1; m_s2 = 1;
      m_start = 0; m_err = 0; m_pend = 0;
    end else begin
      fire = (m_s2 == 0) && (m_low == N - 1);
      acc = fire && ext_en;
      p_old = m_pend;
      done_evt = (m_mode == 2) && conv_done;
      m_low = m_s2 ? 0 : ((m_low < N) ? m_low + 1 : m_low);
      m_s2 = m_s1; m_s1 = ext_trig;
      m_start = 0; set_err = 0; clr = 0;
      case (m_mode)
        0: if (acc && !p_old) begin m_mode = 2; m_start = 1; end
           else begin
             if (acc) set_err = 1;
             if (start_req) begin m_mode = 1; m_left = S - 1; clr = 1; end
           end
        1: begin
             if (acc) set_err = 1;
             if (m_left == 0) begin m_mode = 2; m_start = 1; end else m_left--;
           end
        default: begin
             if (acc) set_err = 1;
             if (conv_done) begin m_mode = 0; m_pend = 1; end
           end
      endcase
      if (!done_evt && result_rd) m_pend = 0;
      m_err = set_err | (m_err & !clr);
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      vectors++;
      if (conv_start !== m_start || err !== m_err) begin
        fails++;
        $display("FAIL per-cycle (R2 R4 R7 R8 R10) start act %b exp %b, error act %b exp %b",
                 conv_start, m_start, err, m_err);
      end
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  always @(negedge clk) if (cycles > 150000) begin
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic check(input string req, input string what, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act %b exp %b", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic pulse_start(); start_req = 1; step(1); start_req = 0; endtask
  task automatic pulse_done();  conv_done = 1; step(1); conv_done = 0; endtask
  task automatic pulse_rd();    result_rd = 1; step(1); result_rd = 0; endtask

  initial begin
    step(3);
    rst_n = 1;
    check("R1", "conv_start_o", conv_start, 1'b0);
    check("R1", "error_o", err, 1'b0);
    step(2);
    ext_en = 1;

    // R2 settled program start, R3 extra request mid-settle ignored
    pulse_start();
    step(9);
    pulse_start();
    step(S - 11);
    check("R2", "start before settle end", conv_start, 1'b0);
    step(1);
    check("R2", "start at settle end", conv_start, 1'b1);
    step(1);
    check("R2", "start one cycle", conv_start, 1'b0);
    pulse_start();                      // R3 request while converting
    step(5);
    check("R3", "no start in conv", conv_start, 1'b0);
    pulse_done();
    step(2);
    check("R9", "no error after done", err, 1'b0);

    // R7 trigger while result unread
    ext_trig = 0;
    step(N + 1);
    check("R7", "error before qualify", err, 1'b0);
    step(1);
    check("R7", "error on unread", err, 1'b1);
    check("R7", "no start on unread", conv_start, 1'b0);
    ext_trig = 1;
    step(3);
    pulse_rd();
    step(2);
    check("R7", "error sticky after read", err, 1'b1);

    // R8 clear by program start; R7 trigger during settle
    pulse_start();
    check("R8", "error cleared", err, 1'b0);
    ext_trig = 0;
    step(N + 2);
    check("R7", "error in settle", err, 1'b1);
    ext_trig = 1;
    step(S);
    pulse_done();
    pulse_rd();
    step(3);

    // R4 immediate external start; R5 held low fires once
    ext_trig = 0;
    step(N + 1);
    check("R4", "start before qualify", conv_start, 1'b0);
    step(1);
    check("R4", "trigger start", conv_start, 1'b1);
    step(1);
    check("R4", "trigger start one cycle", conv_start, 1'b0);
    pulse_done();
    pulse_rd();
    step(30);
    check("R5", "held low no retrigger", conv_start, 1'b0);
    ext_trig = 1;
    step(3);

    // R5 short pulse rejected
    ext_trig = 0;
    step(N - 1);
    ext_trig = 1;
    step(N + 5);
    check("R5", "short pulse rejected", conv_start, 1'b0);

    // R6 disabled trigger
    ext_en = 0;
    ext_trig = 0;
    step(N + 5);
    check("R6", "disabled trigger start", conv_start, 1'b0);
    ext_trig = 1;
    step(3);
    ext_en = 1;

    // R9 done while idle ignored: next trigger still starts
    pulse_done();
    step(2);
    ext_trig = 0;
    step(N + 2);
    check("R9", "trigger after stray done", conv_start, 1'b1);
    ext_trig = 1;
    pulse_done();
    pulse_rd();
    pulse_start();
    check("R8", "error cleared again", err, 1'b0);
    step(S + 2);
    pulse_done();                       // result left unread
    step(2);

    // R8 set wins over clear, program start still proceeds
    ext_trig = 0;
    step(N + 1);
    start_req = 1;
    step(1);
    start_req = 0;
    check("R8", "set wins", err, 1'b1);
    ext_trig = 1;
    step(S - 1);
    check("R8", "start before settle end", conv_start, 1'b0);
    step(1);
    check("R8", "settled start proceeds", conv_start, 1'b1);
    pulse_done();
    pulse_rd();
    step(3);

    // R10 trigger and program start same cycle
    ext_trig = 0;
    step(N + 1);
    start_req = 1;
    step(1);
    start_req = 0;
    check("R10", "trigger wins immediate start", conv_start, 1'b1);
    ext_trig = 1;
    step(S);
    check("R10", "no settled second start", conv_start, 1'b0);
    pulse_done();
    pulse_rd();
    step(5);
    finish_run();
  end
endmodule